// File: doc/BRIEF.md
# Stream Transfer Monitor

This block sits beside one AXI4-Stream link and only listens to it. It never drives any stream signal. A transfer is the run of accepted beats that ends with a TLAST beat. A beat is accepted when TVALID and TREADY are both high at a clock edge. The monitor marks the first accepted beat of each transfer with a one-cycle start pulse and the TLAST beat with a one-cycle stop pulse. These pulses can feed a trace collector further down the chip.

The `STATS_EN` parameter chooses the mode. It defaults to 0, which is the event-only mode. With `STATS_EN = 1` the block also has a small AXI4-Lite slave that exposes two read-only 32-bit counters. The word at byte offset 0x0 holds the beat count of the transfer in progress. The word at byte offset 0x4 holds the beat count of the last completed transfer. The running count moves into the second register in the same edge that accepts the TLAST beat.

Top module: `stream_xfer_monitor`

## Requirements
- R1: A start pulse on `evt_start` is high for exactly the one cycle that follows the first accepted beat of a transfer. A beat is accepted when `mon_tvalid` and `mon_tready` are both high at a rising edge. The first beat of a transfer is the first accepted beat after reset or after a TLAST beat.
- R2: A stop pulse on `evt_stop` is high for exactly the one cycle that follows an accepted beat with `mon_tlast` high.
- R3: A transfer of one beat (TLAST set on its first accepted beat) raises `evt_start` and `evt_stop` in the same cycle. It leaves 1 in the previous-count register.
- R4: A cycle where TVALID or TREADY is low does not count as a beat and causes no event, whatever TLAST is.
- R5: In statistics mode, a read at byte offset 0x0 returns the number of beats accepted so far in the current transfer. The count includes beats up to the edge at which the read address is accepted. It reads 0 between transfers.
- R6: In statistics mode, when the TLAST beat is accepted, the register at byte offset 0x4 takes the count of the finished transfer including that beat. The current count restarts at 0.
- R7: An AXI4-Lite write completes with response 2'b00 (OKAY) and changes neither register.
- R8: A read at any offset whose word index (`s_araddr[ADDR_W-1:2]`) is not 0 or 1 returns 0 with response 2'b00.
- R9: Once `s_bvalid` or `s_rvalid` is raised, it stays high until `s_bready` or `s_rready` is seen. `s_rdata` holds steady over that whole time.
- R10: In the default mode (`STATS_EN = 0`), every AXI4-Lite output stays at 0. The event outputs behave exactly as in statistics mode.
- R11: A synchronous active-high `rst` clears both counters, the in-transfer state and both event outputs. The first beat after reset starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_tvalid | input | 1 | Observed TVALID |
| mon_tready | input | 1 | Observed TREADY |
| mon_tlast | input | 1 | Observed TLAST |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data (discarded) |
| s_wstrb | input | 4 | Write strobes (discarded) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| evt_start | output | 1 | Transfer start pulse |
| evt_stop | output | 1 | Transfer stop pulse |

## Verification
The in-RTL assertions check these on every cycle:
- Each start or stop pulse is backed by an accepted beat one edge earlier, and each stop pulse by a TLAST beat.
- The counters stay put when no beat is accepted.
- The TLAST beat empties the running count into the previous-count register.
- Both AXI4-Lite responses hold steady until they are taken.

Only the bench scenarios can show the values a reader sees:
- The counts read back over AXI4-Lite after stalls, after back-to-back and single-beat transfers, and after a reset in mid-transfer.
- That writes change nothing.
- That the event-only build stays silent on its register port.

// File: rtl/stmon_pkg.sv
package stmon_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STRB_W   = WORD_W / 8;
  localparam logic [1:0]  RESP_OK  = 2'b00;
  localparam int unsigned IDX_CUR  = 0;
  localparam int unsigned IDX_PREV = 1;
endpackage

// File: rtl/stmon_event.sv
module stmon_event (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic last,
  output logic start_evt,
  output logic stop_evt
);
  logic in_xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_xfer   <= 1'b0;
      start_evt <= 1'b0;
      stop_evt  <= 1'b0;
    end else begin
      start_evt <= beat && !in_xfer;
      stop_evt  <= beat && last;
      if (beat) in_xfer <= !last;
    end
  end

  // R1: a start pulse is always preceded by an accepted beat
  a_r1_start_after_beat: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> $past(beat));
  // R2: a stop pulse is always preceded by an accepted TLAST beat
  a_r2_stop_after_last: assert property (@(posedge clk) disable iff (rst)
    stop_evt |-> $past(beat && last));
  // R4: no beat, no event in the next cycle
  a_r4_no_beat_no_event: assert property (@(posedge clk) disable iff (rst)
    !beat |=> !start_evt && !stop_evt);
endmodule

// File: rtl/stmon_count.sv
module stmon_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             last,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [CNT_W-1:0] prev_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_inc;
  assign cur_inc = cur_cnt + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cnt  <= '0;
      prev_cnt <= '0;
    end else if (beat) begin
      if (last) begin
        prev_cnt <= cur_inc;
        cur_cnt  <= '0;
      end else begin
        cur_cnt  <= cur_inc;
      end
    end
  end

  // R6: a TLAST beat empties the running count into the previous register
  a_r6_move_on_last: assert property (@(posedge clk) disable iff (rst)
    (beat && last) |=> (cur_cnt == '0) && (prev_cnt == $past(cur_cnt) + ONE));
  // R4: idle or stalled cycles leave both counters unchanged
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !beat |=> $stable(cur_cnt) && $stable(prev_cnt));
  // R5: a middle beat adds one to the running count
  a_r5_count_up: assert property (@(posedge clk) disable iff (rst)
    (beat && !last) |=> cur_cnt == $past(cur_cnt) + ONE);
endmodule

// File: rtl/stmon_axil.sv
module stmon_axil
  import stmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cur_cnt,
  input  logic [CNT_W-1:0]    prev_cnt,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [WORD_W-1:0]   s_wdata,
  input  logic [STRB_W-1:0]   s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [WORD_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             wr_go, rd_go;
  logic [IDX_W-1:0] rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic             unused_wr;

  assign unused_wr = ^{s_awaddr, s_wdata, s_wstrb, s_araddr[1:0]};

  // writes are accepted only as a pair and only when no response is pending
  assign wr_go     = s_awvalid && s_wvalid && !s_bvalid;
  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_bresp   = RESP_OK;

  always_ff @(posedge clk) begin
    if (rst)          s_bvalid <= 1'b0;
    else if (wr_go)   s_bvalid <= 1'b1;
    else if (s_bready) s_bvalid <= 1'b0;
  end

  assign s_arready = !s_rvalid;
  assign rd_go     = s_arvalid && !s_rvalid;
  assign rd_idx    = s_araddr[ADDR_W-1:2];
  assign s_rresp   = RESP_OK;

  always_comb begin
    if (rd_idx == IDX_W'(IDX_CUR))       rd_word = WORD_W'(cur_cnt);
    else if (rd_idx == IDX_W'(IDX_PREV)) rd_word = WORD_W'(prev_cnt);
    else                                 rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (rd_go) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_word;
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end

  // R9: write response stays up until it is taken
  a_r9_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> s_bvalid);
  // R9: read data stays up and steady until it is taken
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> s_rvalid && $stable(s_rdata));
  // R7: no new write is taken while a response is pending
  a_r7_one_write: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> !s_awready);
endmodule

// File: rtl/stream_xfer_monitor.sv
module stream_xfer_monitor
  import stmon_pkg::*;
#(
  parameter bit          STATS_EN = 1'b0,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon_tvalid,
  input  logic              mon_tready,
  input  logic              mon_tlast,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              evt_start,
  output logic              evt_stop
);
  logic beat;
  assign beat = mon_tvalid && mon_tready;

  stmon_event u_event (
    .clk       (clk),
    .rst       (rst),
    .beat      (beat),
    .last      (mon_tlast),
    .start_evt (evt_start),
    .stop_evt  (evt_stop)
  );

  generate
    if (STATS_EN) begin : g_stats
      logic [CNT_W-1:0] cur_cnt, prev_cnt;

      stmon_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .last     (mon_tlast),
        .cur_cnt  (cur_cnt),
        .prev_cnt (prev_cnt)
      );

      stmon_axil #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_axil (
        .clk       (clk),
        .rst       (rst),
        .cur_cnt   (cur_cnt),
        .prev_cnt  (prev_cnt),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready)
      );
    end else begin : g_basic
      logic unused_bus;
      assign unused_bus = ^{s_awaddr, s_awvalid, s_wdata, s_wstrb, s_wvalid,
                            s_bready, s_araddr, s_arvalid, s_rready};
      assign s_awready = 1'b0;
      assign s_wready  = 1'b0;
      assign s_bresp   = 2'b00;
      assign s_bvalid  = 1'b0;
      assign s_arready = 1'b0;
      assign s_rdata   = '0;
      assign s_rresp   = 2'b00;
      assign s_rvalid  = 1'b0;
    end
  endgenerate
endmodule

// File: tb/stream_xfer_monitor_test.sv
module stream_xfer_monitor_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic tv = 0, tr = 0, tl = 0;
  logic [3:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;

  logic        awready, wready, bvalid, arready, rvalid, st, sp;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        b_awready, b_wready, b_bvalid, b_arready, b_rvalid, b_st, b_sp;
  logic [1:0]  b_bresp, b_rresp;
  logic [31:0] b_rdata;

  stream_xfer_monitor #(.STATS_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .mon_tvalid(tv), .mon_tready(tr), .mon_tlast(tl),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .evt_start(st), .evt_stop(sp));

  stream_xfer_monitor uut_basic (
    .clk(clk), .rst(rst), .mon_tvalid(tv), .mon_tready(tr), .mon_tlast(tl),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(b_awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(b_wready),
    .s_bresp(b_bresp), .s_bvalid(b_bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(b_arready),
    .s_rdata(b_rdata), .s_rresp(b_rresp), .s_rvalid(b_rvalid), .s_rready(rready),
    .evt_start(b_st), .evt_stop(b_sp));

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_in = 0, e_start = 0, e_stop = 0;
  int unsigned m_cur = 0, m_prev = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_in = 0; m_cur = 0; m_prev = 0; e_start = 0; e_stop = 0;
    end else begin
      e_start = tv && tr && !m_in;
      e_stop  = tv && tr && tl;
      if (tv && tr) begin
        m_cur = m_cur + 1;
        if (tl) begin m_prev = m_cur; m_cur = 0; m_in = 0; end
        else m_in = 1;
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk(st == e_start, "R1", "evt_start", st, e_start);
    chk(sp == e_stop,  "R2", "evt_stop",  sp, e_stop);
    chk(b_st == e_start && b_sp == e_stop, "R10", "basic events",
        {b_st, b_sp}, {e_start, e_stop});
    chk({b_awready, b_wready, b_bvalid, b_arready, b_rvalid} == 5'b0 &&
        b_rdata == 0 && b_bresp == 0 && b_rresp == 0, "R10", "basic bus outputs",
        {b_awready, b_wready, b_bvalid, b_arready, b_rvalid}, 0);
  end

  task automatic drive(input bit v, input bit r, input bit l);
    @(negedge clk); tv = v; tr = r; tl = l;
  endtask

  task automatic idle();
    drive(0, 0, 0);
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 0;
    exp = (a[3:2] == 0) ? m_cur : (a[3:2] == 1) ? m_prev : 0;
    @(negedge clk);
    arvalid = 0;
    chk(rvalid == 1, "R9", "rvalid raised", rvalid, 1);
    chk(rdata == exp, req, "rdata", rdata, exp);
    chk(rresp == 0, "R8", "rresp", rresp, 0);
    @(negedge clk);
    chk(rvalid == 1 && rdata == exp, "R9", "rdata held", rdata, exp);
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk(rvalid == 0, "R9", "rvalid dropped", rvalid, 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 0;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk(bvalid == 1 && bresp == 0, "R7", "write OKAY", {bvalid, bresp}, 4);
    @(negedge clk);
    chk(bvalid == 1, "R9", "bvalid held", bvalid, 1);
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk(bvalid == 0, "R9", "bvalid dropped", bvalid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    chk(st == 0 && sp == 0, "R11", "events after reset", {st, sp}, 0);
    rd(4'h0, "R11");
    rd(4'h4, "R11");

    // single-beat transfer
    drive(1, 1, 1); idle();
    rd(4'h4, "R3");
    chk(m_prev == 1, "R3", "model prev", m_prev, 1);

    // four beats with stalls, read in the middle
    drive(1, 0, 1);               // stalled TLAST: ignored
    drive(0, 1, 1);               // ready without valid: ignored
    drive(1, 1, 0); drive(1, 0, 0); drive(1, 1, 0); idle();
    rd(4'h0, "R5");
    rd(4'h0, "R4");
    drive(1, 1, 0); drive(0, 0, 1); drive(1, 1, 1); idle();
    rd(4'h4, "R6");
    rd(4'h0, "R6");

    // back-to-back transfers
    drive(1, 1, 1); drive(1, 1, 0); drive(1, 1, 1); drive(1, 1, 1); idle();
    rd(4'h4, "R6");

    // writes change nothing
    drive(1, 1, 0); drive(1, 1, 0); idle();
    wr(4'h0, 32'hDEAD_BEEF);
    wr(4'h4, 32'h1234_5678);
    rd(4'h0, "R7");
    rd(4'h4, "R7");

    // unmapped offsets
    rd(4'h8, "R8");
    rd(4'hC, "R8");

    // reset in mid-transfer
    drive(1, 1, 0); idle();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    rd(4'h0, "R11");
    rd(4'h4, "R11");
    drive(1, 1, 1); idle();
    rd(4'h4, "R11");
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule